// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Port

This block is the byte-wide bus slave of a two-channel serial controller. Each channel has a control port and a data port. Two address bits choose the port and the channel, and a strap parameter can swap which address bit plays which role. Control accesses reach sixteen write registers and sixteen read registers of the addressed channel. They do so through a per-channel pointer. A write while the pointer is zero loads the pointer. The next control access uses the pointer and then returns it to zero.

The block owns the register storage, the transmit-empty, all-sent and receive-available status bits, and the two-level channel reset. A command field in write register 9 triggers the reset. It clears, keeps or forces selected bits of each register. A hard reset then forces further bits in the clock and line registers.

The serial engine sits next to this block. It receives the write registers as a flat vector, a transmit pulse with the latched byte, and it delivers received bytes through a per-channel strobe.

Top module: `duo_regport`

## Requirements
- R1: A synchronous bus reset zeroes all write and read registers, both pointers, the latched bytes and `rdata`.
- R2: With `SWAP`=0, address bit 0 selects the port (0 control, 1 data) and address bit 1 selects the channel. With `SWAP`=1 the two bits trade roles. Channels never share state.
- R3: A control write while the pointer is 0 loads the pointer with `wdata[2:0]`, plus 8 when `wdata[5:3]` is 3'b001. Any other command value adds nothing.
- R4: A control write while the pointer is nonzero stores `wdata` into that write register and returns the pointer to 0. Write register 0 is never stored.
- R5: A control read returns read register [pointer] on `rdata` one cycle after the strobe, and returns the pointer to 0.
- R6: Writes to write registers 12 and 13 are copied into read registers 12 and 13.
- R7: Writing write register 3 with bit 4 set forces read register 0 bit 4.
- R8: A data write latches the transmit byte and sets read register 0 bit 2 and read register 1 bit 0. In the next cycle `tx_stb` pulses for that channel only if write register 5 bit 3 is set.
- R9: A receive strobe loads the byte and sets read register 0 bit 0, but only when write register 3 bit 0 is set and read register 0 bit 0 is clear. A data read returns the receive byte and clears read register 0 bit 0.
- R10: A write of register 9 whose bits 7:6 are 01 soft-resets channel 0, and 10 soft-resets channel 1. That write is not stored and leaves the writer's pointer unchanged unless the writer itself is reset. A reset channel's pointer and bytes become 0.
- R11: Soft reset sets: WR0=0, WR1&=24h, WR3&=FEh, WR4|=04h, WR5&=61h, WR9&=DFh, WR10&=60h, WR14=(WR14&C3h)|20h, WR15=F8h, RR0=(RR0&B8h)|44h, RR1=(RR1&01h)|06h, RR3=0, RR10&=40h.
- R12: Bits 7:6 equal to 11 hard-reset both channels. This is the soft reset plus: WR9=(WR9&03h)|C0h, WR10=0, WR11=08h, WR14=(WR14&C0h)|30h. `rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high bus reset |
| sel | input | 1 | Access strobe, one cycle per access |
| wr | input | 1 | Write qualifier for `sel` |
| rd | input | 1 | Read qualifier for `sel` |
| addr | input | ADDR_W | Port and channel select bits |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_stb | input | 2 | Per-channel receive byte strobe |
| rx_byte | input | 16 | Per-channel receive byte (channel c at bits 8c+7:8c) |
| tx_stb | output | 2 | Per-channel transmit pulse |
| tx_byte | output | 16 | Per-channel latched transmit byte |
| wregs | output | 256 | All write registers; channel c register i at bits (16c+i)*8 +: 8 |

## Verification
The assertions assume that `wr` and `rd` are never both high with `sel`, and that at most one bus access happens per cycle. The bench keeps to this because every access goes through a single task that raises one qualifier for exactly one cycle, then drops `sel`. The assertions also assume that `rst` is held high from time zero, which the bench does. Receive strobes never coincide with a data read of the same channel, so the gating of accepted bytes is observed without a same-cycle tie.

// File: rtl/duo_regport_pkg.sv
package duo_regport_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 16;
  localparam int PW     = $clog2(NREG);
  localparam int NCH    = 2;
  localparam int HI_OFS = NREG / 2;

  // write register indices
  localparam int IX_IENA   = 1;
  localparam int IX_RXCFG  = 3;
  localparam int IX_TXFMT  = 4;
  localparam int IX_TXCFG  = 5;
  localparam int IX_RSTCMD = 9;
  localparam int IX_LINE   = 10;
  localparam int IX_CLKSRC = 11;
  localparam int IX_DIVLO  = 12;
  localparam int IX_DIVHI  = 13;
  localparam int IX_AUX    = 14;
  localparam int IX_EVMASK = 15;
  // read register indices
  localparam int IX_STAT   = 0;
  localparam int IX_SPEC   = 1;
  localparam int IX_PEND   = 3;
  localparam int IX_MISC   = 10;

  // status bit positions
  localparam int B_RXAV  = 0;
  localparam int B_TXMT  = 2;
  localparam int B_HUNT  = 4;
  localparam int B_SENT  = 0;
  localparam int B_RXEN  = 0;
  localparam int B_TXEN  = 3;

  // soft reset masks
  localparam logic [DW-1:0] SK_IENA  = 8'h24;
  localparam logic [DW-1:0] SC_RXCFG = 8'h01;
  localparam logic [DW-1:0] SS_TXFMT = 8'h04;
  localparam logic [DW-1:0] SK_TXCFG = 8'h61;
  localparam logic [DW-1:0] SC_RST   = 8'h20;
  localparam logic [DW-1:0] SK_LINE  = 8'h60;
  localparam logic [DW-1:0] SK_AUX   = 8'hC3;
  localparam logic [DW-1:0] SS_AUX   = 8'h20;
  localparam logic [DW-1:0] SV_EVM   = 8'hF8;
  localparam logic [DW-1:0] SK_STAT  = 8'hB8;
  localparam logic [DW-1:0] SS_STAT  = 8'h44;
  localparam logic [DW-1:0] SK_SPEC  = 8'h01;
  localparam logic [DW-1:0] SS_SPEC  = 8'h06;
  localparam logic [DW-1:0] SK_MISC  = 8'h40;
  // hard reset extras
  localparam logic [DW-1:0] HK_RST   = 8'h03;
  localparam logic [DW-1:0] HS_RST   = 8'hC0;
  localparam logic [DW-1:0] HV_CLK   = 8'h08;
  localparam logic [DW-1:0] HK_AUX   = 8'hC0;
  localparam logic [DW-1:0] HS_AUX   = 8'h30;

  typedef struct packed {
    logic cw;  // control write
    logic cr;  // control read
    logic dw;  // data write
    logic dr;  // data read
  } acc_t;
endpackage

// File: rtl/duo_port_decode.sv
module duo_port_decode
  import duo_regport_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SHIFT  = 0,
  parameter bit SWAP   = 1'b0
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output acc_t [NCH-1:0]    acc
);
  localparam int REG_BIT = SWAP ? SHIFT + 1 : SHIFT;
  localparam int CHN_BIT = SWAP ? SHIFT : SHIFT + 1;

  logic is_dat;
  logic chn;

  generate
    if (SWAP) begin : g_swapped
      assign is_dat = addr[REG_BIT];
      assign chn    = addr[CHN_BIT];
    end else begin : g_normal
      assign is_dat = addr[REG_BIT];
      assign chn    = addr[CHN_BIT];
    end
  endgenerate

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit       = sel && (chn == 1'(c));
    assign acc[c].cw = hit && wr && !is_dat;
    assign acc[c].cr = hit && rd && !is_dat;
    assign acc[c].dw = hit && wr &&  is_dat;
    assign acc[c].dr = hit && rd &&  is_dat;
  end
endmodule

// File: rtl/duo_chan_regs.sv
module duo_chan_regs
  import duo_regport_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  acc_t               acc,
  input  logic [DW-1:0]      wdata,
  input  logic               soft_rst,
  input  logic               hard_rst,
  input  logic               rx_stb,
  input  logic [DW-1:0]      rx_byte,
  output logic [DW-1:0]      rd_val,
  output logic [1:0]         rst_cmd,
  output logic               tx_stb,
  output logic [DW-1:0]      tx_byte,
  output logic [NREG*DW-1:0] wregs_o
);
  logic [PW-1:0] ptr;
  logic [DW-1:0] wreg [NREG];
  logic [DW-1:0] rreg [NREG];
  logic [DW-1:0] rx_q;
  logic [DW-1:0] tx_q;
  logic          tx_stb_q;
  logic          cmd_wr;
  logic          rx_take;
  logic          pt_hi;
  logic [PW-1:0] ptr_new;

  assign cmd_wr  = acc.cw && (ptr == PW'(IX_RSTCMD)) && (wdata[7:6] != 2'b00);
  assign rst_cmd = cmd_wr ? wdata[7:6] : 2'b00;
  assign rx_take = rx_stb && wreg[IX_RXCFG][B_RXEN] && !rreg[IX_STAT][B_RXAV];
  assign pt_hi   = (wdata[5:3] == 3'b001);
  assign ptr_new = PW'(wdata[2:0]) + (pt_hi ? PW'(HI_OFS) : '0);
  assign rd_val  = acc.cr ? rreg[ptr] : rx_q;
  assign tx_stb  = tx_stb_q;
  assign tx_byte = tx_q;

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign wregs_o[i*DW +: DW] = wreg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      tx_stb_q <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        wreg[i] <= '0;
        rreg[i] <= '0;
      end
    end else if (soft_rst || hard_rst) begin
      ptr      <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      tx_stb_q <= 1'b0;
      wreg[0]          <= '0;
      wreg[IX_IENA]    <= wreg[IX_IENA] & SK_IENA;
      wreg[IX_RXCFG]   <= wreg[IX_RXCFG] & ~SC_RXCFG;
      wreg[IX_TXFMT]   <= wreg[IX_TXFMT] | SS_TXFMT;
      wreg[IX_TXCFG]   <= wreg[IX_TXCFG] & SK_TXCFG;
      wreg[IX_EVMASK]  <= SV_EVM;
      rreg[IX_STAT]    <= (rreg[IX_STAT] & SK_STAT) | SS_STAT;
      rreg[IX_SPEC]    <= (rreg[IX_SPEC] & SK_SPEC) | SS_SPEC;
      rreg[IX_PEND]    <= '0;
      rreg[IX_MISC]    <= rreg[IX_MISC] & SK_MISC;
      if (hard_rst) begin
        wreg[IX_RSTCMD] <= (wreg[IX_RSTCMD] & HK_RST) | HS_RST;
        wreg[IX_LINE]   <= '0;
        wreg[IX_CLKSRC] <= HV_CLK;
        wreg[IX_AUX]    <= (wreg[IX_AUX] & HK_AUX) | HS_AUX;
      end else begin
        wreg[IX_RSTCMD] <= wreg[IX_RSTCMD] & ~SC_RST;
        wreg[IX_LINE]   <= wreg[IX_LINE] & SK_LINE;
        wreg[IX_AUX]    <= (wreg[IX_AUX] & SK_AUX) | SS_AUX;
      end
    end else begin
      tx_stb_q <= 1'b0;
      if (acc.cw && !cmd_wr) begin
        if (ptr == '0) begin
          ptr <= ptr_new;
        end else begin
          ptr       <= '0;
          wreg[ptr] <= wdata;
          if (ptr == PW'(IX_RXCFG) && wdata[B_HUNT])
            rreg[IX_STAT][B_HUNT] <= 1'b1;
          if (ptr == PW'(IX_DIVLO) || ptr == PW'(IX_DIVHI))
            rreg[ptr] <= wdata;
        end
      end
      if (acc.cr) ptr <= '0;
      if (acc.dw) begin
        tx_q                  <= wdata;
        rreg[IX_STAT][B_TXMT] <= 1'b1;
        rreg[IX_SPEC][B_SENT] <= 1'b1;
        tx_stb_q              <= wreg[IX_TXCFG][B_TXEN];
      end
      if (acc.dr) rreg[IX_STAT][B_RXAV] <= 1'b0;
      if (rx_take) begin
        rx_q                  <= rx_byte;
        rreg[IX_STAT][B_RXAV] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/duo_regport.sv
module duo_regport
  import duo_regport_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SHIFT  = 0,
  parameter bit SWAP   = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NCH-1:0]         rx_stb,
  input  logic [NCH*DW-1:0]      rx_byte,
  output logic [NCH-1:0]         tx_stb,
  output logic [NCH*DW-1:0]      tx_byte,
  output logic [NCH*NREG*DW-1:0] wregs
);
  acc_t [NCH-1:0]          acc;
  logic [NCH-1:0][DW-1:0]  rd_val;
  logic [NCH-1:0][1:0]     rst_cmd;
  logic [1:0]              cmd_any;
  logic [NCH-1:0]          soft_v;
  logic                    hard;
  logic [DW-1:0]           rd_mux;
  logic                    rd_any;

  duo_port_decode #(.ADDR_W(ADDR_W), .SHIFT(SHIFT), .SWAP(SWAP)) u_dec (
    .sel(sel), .wr(wr), .rd(rd), .addr(addr), .acc(acc)
  );

  // bit c of the command field resets channel c; both bits give a hard reset
  always_comb begin
    cmd_any = '0;
    for (int c = 0; c < NCH; c++) cmd_any |= rst_cmd[c];
  end
  assign hard   = &cmd_any;
  assign soft_v = hard ? '0 : cmd_any;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    duo_chan_regs u_ch (
      .clk(clk), .rst(rst), .acc(acc[c]), .wdata(wdata),
      .soft_rst(soft_v[c]), .hard_rst(hard),
      .rx_stb(rx_stb[c]), .rx_byte(rx_byte[c*DW +: DW]),
      .rd_val(rd_val[c]), .rst_cmd(rst_cmd[c]),
      .tx_stb(tx_stb[c]), .tx_byte(tx_byte[c*DW +: DW]),
      .wregs_o(wregs[c*NREG*DW +: NREG*DW])
    );
  end

  always_comb begin
    rd_mux = '0;
    rd_any = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (acc[c].cr || acc[c].dr) begin
        rd_mux = rd_val[c];
        rd_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_any) rdata <= rd_mux;
  end
endmodule

// File: rtl/duo_regport_chk.sv
module duo_regport_chk
  import duo_regport_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wr,
  input logic              rd,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [NCH-1:0]    tx_stb,
  input logic [NCH*DW-1:0] tx_byte
);
  a_r1_rdata_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata == '0));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |=> $stable(rdata));

  a_r8_tx_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_stb));

  a_r8_tx_cause: assert property (@(posedge clk) disable iff (rst)
    (tx_stb != '0) |-> $past(sel && wr));

  a_r8_tx_idle: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (tx_stb == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_tx
    a_r8_tx_byte: assert property (@(posedge clk) disable iff (rst)
      tx_stb[c] |-> (tx_byte[c*DW +: DW] == $past(wdata)));
  end
endmodule

bind duo_regport duo_regport_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .wdata(wdata),
  .rdata(rdata), .tx_stb(tx_stb), .tx_byte(tx_byte)
);

// File: tb/duo_regport_tb.sv
module duo_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, rdata_sw;
  logic [1:0]  rx_stb = '0;
  logic [15:0] rx_byte = '0;
  logic [1:0]  tx_stb, tx_stb_sw;
  logic [15:0] tx_byte, tx_byte_sw;
  logic [255:0] wregs, wregs_sw;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  duo_regport u_dut (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_stb(tx_stb), .tx_byte(tx_byte), .wregs(wregs)
  );

  duo_regport #(.SWAP(1'b1)) u_swp (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata_sw), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_stb(tx_stb_sw), .tx_byte(tx_byte_sw), .wregs(wregs_sw)
  );

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wv(logic [255:0] v, int ch, int ix);
    return v[(ch*16 + ix)*8 +: 8];
  endfunction

  // address: bit0 = data port, bit1 = channel (default strap)
  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    sel = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic set_ptr(int ch, int ix);
    if (ix >= 8) bus_wr(2'(ch*2), 8'(ix - 8) | 8'h08);
    else if (ix != 0) bus_wr(2'(ch*2), 8'(ix));
  endtask

  task automatic ctl_wr(int ch, int ix, logic [7:0] v);
    set_ptr(ch, ix);
    bus_wr(2'(ch*2), v);
  endtask

  task automatic ctl_rd(int ch, int ix, logic [7:0] exp, string tag);
    set_ptr(ch, ix);
    bus_rd(2'(ch*2), exp, tag);
  endtask

  task automatic rx_put(int ch, logic [7:0] b);
    @(negedge clk);
    rx_stb[ch] = 1'b1; rx_byte[ch*8 +: 8] = b;
    @(negedge clk);
    rx_stb = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic take;
      @(posedge clk);
      take = sel && rd;
      #1;
      if (take) begin
        if (exp_q.size() == 0) begin
          checks++; errs++;
          $display("FAIL R5 unexpected read act=%02h exp=none", rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk8(t, rdata, e);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      checks++; errs++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk8("R1 rdata", rdata, 8'h00);
    chk8("R1 wregs zero", 8'(|wregs), 8'h00);
    chk8("R1 tx_byte", tx_byte[7:0], 8'h00);
    bus_rd(2'b00, 8'h00, "R1 RR0 ch0");

    // R3 pointer high, R6 mirror, R2 channel separation
    ctl_wr(1, 12, 8'h5A);
    ctl_wr(1, 13, 8'hA5);
    ctl_rd(1, 12, 8'h5A, "R6 RR12 ch1");
    ctl_rd(1, 13, 8'hA5, "R6 RR13 ch1");
    ctl_rd(0, 12, 8'h00, "R2 RR12 ch0 untouched");
    chk8("R4 WR12 ch1", wv(wregs, 1, 12), 8'h5A);
    chk8("R2 WR12 ch0", wv(wregs, 0, 12), 8'h00);
    // R5 pointer back to zero after read
    bus_rd(2'b10, 8'h00, "R5 raw read gives RR0");
    // R3 other command value does not add 8
    bus_wr(2'b10, 8'h2C);
    bus_wr(2'b10, 8'h99);
    chk8("R3 WR4 ch1", wv(wregs, 1, 4), 8'h99);
    chk8("R3 WR12 ch1 kept", wv(wregs, 1, 12), 8'h5A);
    chk8("R4 WR0 never stored", wv(wregs, 1, 0), 8'h00);

    // R7 hunt
    ctl_wr(0, 3, 8'h11);
    ctl_rd(0, 0, 8'h10, "R7 RR0 hunt");

    // R9 receive
    rx_put(0, 8'h3C);
    bus_rd(2'b00, 8'h11, "R9 RR0 rx avail");
    bus_rd(2'b01, 8'h3C, "R9 data read");
    bus_rd(2'b00, 8'h10, "R9 RR0 cleared");
    rx_put(0, 8'h77);
    rx_put(0, 8'h88);
    bus_rd(2'b01, 8'h77, "R9 second byte dropped");
    rx_put(1, 8'hEE);
    bus_rd(2'b10, 8'h00, "R9 rx disabled RR0");
    bus_rd(2'b11, 8'h00, "R9 rx disabled byte");

    // R8 transmit
    ctl_wr(0, 5, 8'h08);
    bus_wr(2'b01, 8'h6B);
    chk8("R8 tx_stb", 8'(tx_stb), 8'h01);
    chk8("R8 tx_byte", tx_byte[7:0], 8'h6B);
    @(negedge clk);
    chk8("R8 tx_stb one cycle", 8'(tx_stb), 8'h00);
    ctl_rd(0, 0, 8'h14, "R8 RR0 tx empty");
    ctl_rd(0, 1, 8'h01, "R8 RR1 all sent");
    bus_wr(2'b11, 8'hC4);
    chk8("R8 tx disabled no pulse", 8'(tx_stb), 8'h00);
    chk8("R8 tx byte latched", tx_byte[15:8], 8'hC4);

    // R10/R11 soft reset of ch0 from ch0
    ctl_wr(0, 1, 8'hFF);
    ctl_wr(0, 4, 8'h00);
    ctl_wr(0, 5, 8'hFF);
    ctl_wr(0, 10, 8'hFF);
    ctl_wr(0, 14, 8'hFF);
    ctl_wr(0, 11, 8'h55);
    ctl_wr(0, 9, 8'h3F);
    chk8("R4 WR9 stored", wv(wregs, 0, 9), 8'h3F);
    ctl_wr(0, 9, 8'h40);
    chk8("R11 WR1", wv(wregs, 0, 1), 8'h24);
    chk8("R11 WR3", wv(wregs, 0, 3), 8'h10);
    chk8("R11 WR4", wv(wregs, 0, 4), 8'h04);
    chk8("R11 WR5", wv(wregs, 0, 5), 8'h61);
    chk8("R11 WR9", wv(wregs, 0, 9), 8'h1F);
    chk8("R11 WR10", wv(wregs, 0, 10), 8'h60);
    chk8("R11 WR11 kept", wv(wregs, 0, 11), 8'h55);
    chk8("R11 WR14", wv(wregs, 0, 14), 8'hE3);
    chk8("R11 WR15", wv(wregs, 0, 15), 8'hF8);
    chk8("R10 ch1 untouched", wv(wregs, 1, 15), 8'h00);
    bus_rd(2'b00, 8'h54, "R10 ptr reset RR0");
    ctl_rd(0, 1, 8'h07, "R11 RR1");
    bus_rd(2'b01, 8'h00, "R10 rx byte cleared");

    // R10 cross-channel: ch0 resets ch1, ch0 pointer stays at 9
    ctl_wr(0, 9, 8'h80);
    chk8("R10 ch1 WR15", wv(wregs, 1, 15), 8'hF8);
    chk8("R10 ch1 WR12 kept", wv(wregs, 1, 12), 8'h5A);
    chk8("R10 cmd not stored", wv(wregs, 0, 9), 8'h1F);
    bus_wr(2'b00, 8'h02);
    chk8("R10 writer ptr kept", wv(wregs, 0, 9), 8'h02);
    ctl_rd(0, 1, 8'h07, "R10 ptr back to 0");
    ctl_rd(1, 0, 8'h44, "R11 ch1 RR0");

    // R12 hard reset from ch1
    ctl_wr(1, 9, 8'h03);
    ctl_wr(1, 14, 8'hFF);
    ctl_wr(1, 10, 8'hAA);
    ctl_wr(1, 9, 8'hC0);
    chk8("R12 ch1 WR9", wv(wregs, 1, 9), 8'hC3);
    chk8("R12 ch1 WR10", wv(wregs, 1, 10), 8'h00);
    chk8("R12 ch1 WR11", wv(wregs, 1, 11), 8'h08);
    chk8("R12 ch1 WR14", wv(wregs, 1, 14), 8'hF0);
    chk8("R12 ch0 WR9", wv(wregs, 0, 9), 8'hC2);
    chk8("R12 ch0 WR11", wv(wregs, 0, 11), 8'h08);
    chk8("R12 ch0 WR14", wv(wregs, 0, 14), 8'hF0);
    chk8("R12 ch0 WR10", wv(wregs, 0, 10), 8'h00);
    bus_rd(2'b10, 8'h44, "R12 ch1 ptr reset RR0");
    ctl_rd(1, 12, 8'h5A, "R12 RR12 kept");
    repeat (3) @(negedge clk);
    chk8("R12 rdata holds", rdata, 8'h5A);

    // R2 swapped strap: bit0 channel, bit1 port
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    bus_wr(2'b01, 8'h0C);
    bus_wr(2'b01, 8'h3D);
    chk8("R2 swap WR12 ch1", wv(wregs_sw, 1, 12), 8'h3D);
    chk8("R2 swap WR12 ch0", wv(wregs_sw, 0, 12), 8'h00);
    bus_wr(2'b10, 8'h81);
    chk8("R2 swap data ch0", tx_byte_sw[7:0], 8'h81);

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errs++;
      $display("FAIL R5 pending reads act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule